// File: doc/BRIEF.md
# Multi-Mode Write General Register File

This block stores 32 general registers of 64 bits each and serves four independent read ports and two write ports in every cycle. Bits are numbered from the most significant end: architectural bit 0 is the MSB (vector index 63) and bit 63 is the LSB (vector index 0). The "high word" is architectural bits 0:31 (vector [63:32]). The "low word" is bits 32:63 (vector [31:0]).

Each write port carries a 2-bit mode. The mode picks one of four updates. The port can write only the high word or only the low word of one register. It can write the whole doubleword. In pair mode it splits one 64-bit write word across the low halves of an even register and the odd register that follows it. Words that only one port touches in a cycle are merged into the register. If both ports hit the same word, write port 1 wins. Reads are combinational from the stored state, so a read in the same cycle as a write returns the old value.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset, active high, clears all 32 registers to zero and clears both error flags.
- R2: Mode 2'b10 (full) writes the whole 64-bit data word into the addressed register.
- R3: Mode 2'b00 (high word) writes data bits 0:31 (vector [63:32]) into register bits 0:31 and leaves bits 32:63 unchanged.
- R4: Mode 2'b01 (low word) writes data bits 32:63 (vector [31:0]) into register bits 32:63 and leaves bits 0:31 unchanged.
- R5: Mode 2'b11 (pair) with an even address A writes data bits 0:31 into bits 32:63 of register A, and data bits 32:63 into bits 32:63 of register A+1.
- R6: Pair mode leaves bits 0:31 of both registers of the pair unchanged.
- R7: Pair mode with an odd address changes no register and raises that port's error flag (wr_err_o bit = port number) in the cycle after the write edge. The flag is low in every other cycle.
- R8: When both write ports update the same word of the same register in one cycle, the value from write port 1 is stored.
- R9: When the two write ports update different words of the same register in one cycle, both updates take effect.
- R10: A read of a register in the same cycle as a write to it returns the value held before the write. The new value is readable from the next cycle.
- R11: Each of the four read ports returns the full 64-bit register at its own address, independent of the other ports.
- R12: A write port whose enable is low changes nothing, whatever its address, mode and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr0_en_i | input | 1 | Write port 0 enable |
| wr0_addr_i | input | 5 | Write port 0 register address |
| wr0_mode_i | input | 2 | Write port 0 mode (00 high, 01 low, 10 full, 11 pair) |
| wr0_data_i | input | 64 | Write port 0 data |
| wr1_en_i | input | 1 | Write port 1 enable |
| wr1_addr_i | input | 5 | Write port 1 register address |
| wr1_mode_i | input | 2 | Write port 1 mode |
| wr1_data_i | input | 64 | Write port 1 data |
| rd_addr_i | input | 4x5 | Read addresses, one per read port |
| rd_data_o | output | 4x64 | Read data, one per read port |
| wr_err_o | output | 2 | Odd-address pair error flag, one per write port |

## Verification
A wrong word enable or a wrong word select corrupts one half of a register. That error stays hidden until a read port addresses that register, and it shows one cycle after the faulty write edge. The bench therefore reads back every register that could have been touched, including the partner register of a pair and the untouched half of a word write. A fault in the port priority or in the pair-address check also shows on the first readback after the conflicting write, and the flag error shows in that same cycle on wr_err_o.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    typedef enum logic [1:0] {
        WM_HIGH = 2'b00,
        WM_LOW  = 2'b01,
        WM_FULL = 2'b10,
        WM_PAIR = 2'b11
    } wmode_e;
endpackage

// File: rtl/gpr_wr_decode.sv
module gpr_wr_decode
    import gpr_pkg::*;
#(
    parameter int unsigned NREG  = 32,
    parameter int unsigned WIDTH = 64,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned HALF = WIDTH / 2
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       we_i,
    input  logic [AW-1:0]              addr_i,
    input  wmode_e                     mode_i,
    input  logic [WIDTH-1:0]           data_i,
    output logic [NREG-1:0]            hi_en_o,
    output logic [NREG-1:0]            lo_en_o,
    output logic [HALF-1:0]            hi_val_o,
    output logic [NREG-1:0][HALF-1:0]  lo_val_o,
    output logic                       pair_err_o
);
    logic [AW-1:0] odd_addr;
    assign odd_addr = {addr_i[AW-1:1], 1'b1};

    always_comb begin
        hi_en_o    = '0;
        lo_en_o    = '0;
        lo_val_o   = '0;
        hi_val_o   = data_i[WIDTH-1:HALF];
        pair_err_o = 1'b0;
        if (we_i) begin
            case (mode_i)
                WM_HIGH: hi_en_o[addr_i] = 1'b1;
                WM_LOW: begin
                    lo_en_o[addr_i]  = 1'b1;
                    lo_val_o[addr_i] = data_i[HALF-1:0];
                end
                WM_FULL: begin
                    hi_en_o[addr_i]  = 1'b1;
                    lo_en_o[addr_i]  = 1'b1;
                    lo_val_o[addr_i] = data_i[HALF-1:0];
                end
                default: begin
                    if (addr_i[0]) begin
                        pair_err_o = 1'b1;
                    end else begin
                        lo_en_o[addr_i]    = 1'b1;
                        lo_val_o[addr_i]   = data_i[WIDTH-1:HALF];
                        lo_en_o[odd_addr]  = 1'b1;
                        lo_val_o[odd_addr] = data_i[HALF-1:0];
                    end
                end
            endcase
        end
    end

    // R6
    pair_hi_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && mode_i == WM_PAIR) |-> (hi_en_o == '0));

    // R7
    odd_pair_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (we_i && mode_i == WM_PAIR && addr_i[0]) |-> (lo_en_o == '0 && hi_en_o == '0));

    // R12
    idle_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !we_i |-> (lo_en_o == '0 && hi_en_o == '0 && !pair_err_o));

    // R5
    word_count_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ($countones(hi_en_o) <= 1) && ($countones(lo_en_o) <= 2));
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned WIDTH = 64,
    localparam int unsigned AW   = $clog2(NREG)
) (
    input  logic [NREG-1:0][WIDTH-1:0] regs_i,
    input  logic [AW-1:0]              addr_i,
    output logic [WIDTH-1:0]           data_o
);
    always_comb begin
        data_o = regs_i[addr_i];
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
#(
    parameter int unsigned NREG  = 32,
    parameter int unsigned WIDTH = 64,
    parameter int unsigned NRD   = 4,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned HALF = WIDTH / 2,
    localparam int unsigned NWR  = 2
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      wr0_en_i,
    input  logic [AW-1:0]             wr0_addr_i,
    input  logic [1:0]                wr0_mode_i,
    input  logic [WIDTH-1:0]          wr0_data_i,
    input  logic                      wr1_en_i,
    input  logic [AW-1:0]             wr1_addr_i,
    input  logic [1:0]                wr1_mode_i,
    input  logic [WIDTH-1:0]          wr1_data_i,
    input  logic [NRD-1:0][AW-1:0]    rd_addr_i,
    output logic [NRD-1:0][WIDTH-1:0] rd_data_o,
    output logic [NWR-1:0]            wr_err_o
);
    typedef struct packed {
        logic [NREG-1:0][WIDTH-1:0] regs;
        logic [NWR-1:0]             err;
    } state_t;

    state_t state_d, state_q;

    logic   [NWR-1:0]                      we;
    logic   [NWR-1:0][AW-1:0]              waddr;
    wmode_e                                wmode [NWR];
    logic   [NWR-1:0][WIDTH-1:0]           wdata;
    logic   [NWR-1:0][NREG-1:0]            hi_en;
    logic   [NWR-1:0][NREG-1:0]            lo_en;
    logic   [NWR-1:0][HALF-1:0]            hi_val;
    logic   [NWR-1:0][NREG-1:0][HALF-1:0]  lo_val;
    logic   [NWR-1:0]                      pair_err;

    assign we       = {wr1_en_i, wr0_en_i};
    assign waddr    = {wr1_addr_i, wr0_addr_i};
    assign wdata    = {wr1_data_i, wr0_data_i};
    assign wmode[0] = wmode_e'(wr0_mode_i);
    assign wmode[1] = wmode_e'(wr1_mode_i);

    for (genvar p = 0; p < NWR; p++) begin : g_wr
        gpr_wr_decode #(.NREG(NREG), .WIDTH(WIDTH)) u_dec (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .we_i       (we[p]),
            .addr_i     (waddr[p]),
            .mode_i     (wmode[p]),
            .data_i     (wdata[p]),
            .hi_en_o    (hi_en[p]),
            .lo_en_o    (lo_en[p]),
            .hi_val_o   (hi_val[p]),
            .lo_val_o   (lo_val[p]),
            .pair_err_o (pair_err[p])
        );
    end

    // Port 1 is applied last so it wins on a shared word.
    always_comb begin
        state_d     = state_q;
        state_d.err = pair_err;
        for (int r = 0; r < NREG; r++) begin
            for (int p = 0; p < NWR; p++) begin
                if (hi_en[p][r]) state_d.regs[r][WIDTH-1:HALF] = hi_val[p];
                if (lo_en[p][r]) state_d.regs[r][HALF-1:0]     = lo_val[p][r];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= '0;
        else       state_q <= state_d;
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        gpr_read_port #(.NREG(NREG), .WIDTH(WIDTH)) u_rd (
            .regs_i (state_q.regs),
            .addr_i (rd_addr_i[k]),
            .data_o (rd_data_o[k])
        );
    end

    assign wr_err_o = state_q.err;

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (state_q.regs == '0 && state_q.err == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!wr0_en_i && !wr1_en_i) |=> $stable(state_q.regs));

    // R7
    odd_pair_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr0_en_i && wr0_mode_i == 2'b11 && wr0_addr_i[0] && !wr1_en_i)
        |=> ($stable(state_q.regs) && wr_err_o[0]));

    // R8
    port1_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr0_en_i && wr1_en_i && wr0_mode_i == 2'b10 && wr1_mode_i == 2'b10
         && wr0_addr_i == wr1_addr_i)
        |=> (rd_data_o[0] == $past(wr1_data_i) || rd_addr_i[0] != $past(wr1_addr_i)));
endmodule

// File: tb/gpr_file_tb.sv
module gpr_file_tb;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              w0_en = 1'b0, w1_en = 1'b0;
    logic [4:0]        w0_addr = '0, w1_addr = '0;
    logic [1:0]        w0_mode = '0, w1_mode = '0;
    logic [63:0]       w0_data = '0, w1_data = '0;
    logic [3:0][4:0]   rd_addr = '0;
    logic [3:0][63:0]  rd_data;
    logic [1:0]        wr_err;

    logic [63:0] mdl [32];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpr_file u_dut (
        .clk_i(clk), .rst_i(rst),
        .wr0_en_i(w0_en), .wr0_addr_i(w0_addr), .wr0_mode_i(w0_mode), .wr0_data_i(w0_data),
        .wr1_en_i(w1_en), .wr1_addr_i(w1_addr), .wr1_mode_i(w1_mode), .wr1_data_i(w1_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wr_err_o(wr_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected-state model built from the mode rules
    task automatic model_apply(input logic en, input logic [4:0] a, input logic [1:0] m,
                               input logic [63:0] d);
        if (en) begin
            case (m)
                2'b00: mdl[a][63:32] = d[63:32];
                2'b01: mdl[a][31:0]  = d[31:0];
                2'b10: mdl[a]        = d;
                default: if (!a[0]) begin
                    mdl[a][31:0]     = d[63:32];
                    mdl[a + 1][31:0] = d[31:0];
                end
            endcase
        end
    endtask

    task automatic do_write(input logic e0, input logic [4:0] a0, input logic [1:0] m0,
                            input logic [63:0] d0, input logic e1, input logic [4:0] a1,
                            input logic [1:0] m1, input logic [63:0] d1);
        @(negedge clk);
        w0_en = e0; w0_addr = a0; w0_mode = m0; w0_data = d0;
        w1_en = e1; w1_addr = a1; w1_mode = m1; w1_data = d1;
        @(posedge clk);
        #1;
        model_apply(e0, a0, m0, d0);
        model_apply(e1, a1, m1, d1);
        w0_en = 1'b0; w1_en = 1'b0;
    endtask

    task automatic check_reg(input string req, input int r);
        rd_addr[r % 4] = r[4:0];
        #1;
        chk(req, rd_data[r % 4], mdl[r]);
    endtask

    task automatic t_reset;
        for (int r = 0; r < 32; r++) mdl[r] = '0;
        for (int r = 0; r < 32; r++) check_reg("R1 reset clears", r);
        chk("R1 err flags clear", {62'd0, wr_err}, 64'd0);
    endtask

    task automatic t_full;
        do_write(1, 5, 2'b10, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0);
        check_reg("R2 full write", 5);
        check_reg("R2 neighbour untouched", 4);
    endtask

    task automatic t_high;
        do_write(1, 5, 2'b00, 64'hDEAD_BEEF_1111_2222, 0, 0, 0, 0);
        check_reg("R3 high word only", 5);
    endtask

    task automatic t_low;
        do_write(1, 5, 2'b01, 64'h3333_4444_CAFE_F00D, 0, 0, 0, 0);
        check_reg("R4 low word only", 5);
    endtask

    task automatic t_pair;
        do_write(1, 10, 2'b10, 64'hAAAA_AAAA_AAAA_AAAA, 1, 11, 2'b10, 64'hBBBB_BBBB_BBBB_BBBB);
        do_write(0, 0, 0, 0, 1, 10, 2'b11, 64'h1234_5678_9ABC_DEF0);
        check_reg("R5 pair even gets data hi", 10);
        check_reg("R5 pair odd gets data lo", 11);
        chk("R6 even high kept", {32'd0, rd_data[10 % 4][63:32]}, 64'h0000_0000_AAAA_AAAA);
        chk("R6 odd high kept", {32'd0, rd_data[11 % 4][63:32]}, 64'h0000_0000_BBBB_BBBB);
        do_write(1, 30, 2'b11, 64'h5555_6666_7777_8888, 0, 0, 0, 0);
        check_reg("R5 pair at top even", 30);
        check_reg("R5 pair top odd", 31);
    endtask

    task automatic t_odd_pair;
        do_write(1, 12, 2'b10, 64'h0F0F_0F0F_0F0F_0F0F, 1, 13, 2'b10, 64'hF0F0_F0F0_F0F0_F0F0);
        do_write(1, 13, 2'b11, 64'h9999_9999_9999_9999, 0, 0, 0, 0);
        chk("R7 err flag port0", {62'd0, wr_err}, 64'd1);
        check_reg("R7 odd pair no write", 13);
        check_reg("R7 next reg untouched", 14);
        check_reg("R7 prev reg untouched", 12);
        do_write(0, 0, 0, 0, 1, 15, 2'b11, 64'h1);
        chk("R7 err flag port1", {62'd0, wr_err}, 64'd2);
        do_write(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 flag drops", {62'd0, wr_err}, 64'd0);
    endtask

    task automatic t_priority;
        do_write(1, 7, 2'b10, 64'h1111_1111_1111_1111, 1, 7, 2'b10, 64'h2222_2222_2222_2222);
        check_reg("R8 port1 wins full", 7);
        do_write(1, 8, 2'b10, 64'h0, 1, 8, 2'b11, 64'hABCD_0000_0000_0000);
        check_reg("R8 port1 wins low word", 8);
        check_reg("R8 pair partner", 9);
    endtask

    task automatic t_merge;
        do_write(1, 20, 2'b00, 64'h7777_7777_0000_0000, 1, 20, 2'b01, 64'h0000_0000_8888_8888);
        check_reg("R9 two ports merge", 20);
        do_write(1, 21, 2'b00, 64'hCCCC_CCCC_0000_0000, 1, 20, 2'b11, 64'h4444_4444_5555_5555);
        check_reg("R9 pair and high merge reg20", 20);
        check_reg("R9 pair and high merge reg21", 21);
    endtask

    task automatic t_rdw;
        logic [63:0] old_v;
        old_v = mdl[3];
        @(negedge clk);
        w0_en = 1'b1; w0_addr = 5'd3; w0_mode = 2'b10; w0_data = 64'hFEED_FACE_0BAD_F00D;
        rd_addr[2] = 5'd3;
        #1;
        chk("R10 read sees old value", rd_data[2], old_v);
        @(posedge clk);
        #1;
        model_apply(1'b1, 5'd3, 2'b10, 64'hFEED_FACE_0BAD_F00D);
        w0_en = 1'b0;
        chk("R10 new value next cycle", rd_data[2], 64'hFEED_FACE_0BAD_F00D);
    endtask

    task automatic t_four_read;
        rd_addr[0] = 5'd5; rd_addr[1] = 5'd7; rd_addr[2] = 5'd20; rd_addr[3] = 5'd30;
        #1;
        chk("R11 port0", rd_data[0], mdl[5]);
        chk("R11 port1", rd_data[1], mdl[7]);
        chk("R11 port2", rd_data[2], mdl[20]);
        chk("R11 port3", rd_data[3], mdl[30]);
    endtask

    task automatic t_idle;
        do_write(0, 5, 2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 0, 10, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
        check_reg("R12 disabled port0 no effect", 5);
        check_reg("R12 disabled port1 no effect", 10);
        check_reg("R12 disabled pair partner", 11);
        chk("R12 no flag", {62'd0, wr_err}, 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_full();
        t_high();
        t_low();
        t_pair();
        t_odd_pair();
        t_priority();
        t_merge();
        t_rdw();
        t_four_read();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule